// File: doc/BRIEF.md
# Indexed Voice Register Access Port

This block is the host-facing register window of a multi-voice wavetable synthesizer. The host never addresses a voice register directly. It first stores a voice number and a function code in two select registers. It then moves data through a pair of data ports. The low data port carries a full word or its lower byte. The high data port carries the upper byte only. Function codes that name a per-voice register resolve to one word of a voices-by-slots register array held in synchronous RAM. The other function codes resolve to global byte registers. Those registers are the DMA control, timer control, sample control, active-voice count and the global reset/enable register.

Two further function codes build a 20-bit sample-memory pointer, in a low part and a high part. A byte-wide sample-memory port on the host bus then reads or writes external sample memory at that pointer. Writing the reset register with bit 0 clear returns the global state to a known condition and drops the interrupt line. While that bit stays clear, every per-voice write is discarded. The synthesis engine reports voice events on a plain bit vector. These events set pending flags, and the interrupt output is the OR of those flags.

Host port codes on `host_addr`: 0 voice select, 1 function select, 2 low data port, 3 high data port, 4 sample-memory data. Codes 5 to 7 are ignored on write and read as zero. Every host read returns its data on `host_rdata` one cycle after the strobe, and the value stays there until the next read. The host bus is a plain strobe interface with no back-pressure: each strobe completes in the cycle it is given, and the host may issue one operation per cycle.

Top module: `vrp_port`

## Requirements
- R1: A function code whose bits 6:4 are zero and whose bits 3:0 are below 14 (0x00-0x0D, 0x80-0x8D) selects per-voice word `{voice_select[4:0], function[3:0]}`. Bits 7:5 of the voice select have no effect on that address.
- R2: A byte write on the low data port changes only bits 7:0 of the selected per-voice word. A word write (`host_word`=1) on the low data port replaces all 16 bits.
- R3: A write on the high data port places data bits 7:0 into bits 15:8 of the selected per-voice word and leaves bits 7:0 unchanged, whatever the value of `host_word`.
- R4: A per-voice read on the low data port returns the whole word. A read on the high data port returns the word shifted right by 8. Read data appears after the rising edge that samples `host_rd` and holds until the next read.
- R5: Per-voice writes have no effect while bit 0 of the reset register (function 0x4C) is 0. This is the case after `rst_n`.
- R6: Function 0x43 writes pointer bits 15:0 by lane, using the rules of R2/R3, and keeps bits 19:16. Function 0x44 sets pointer bits 19:16 from data bits 3:0. The pointer appears on `smem_addr`.
- R7: A write to port 4 asserts `smem_we` in that cycle, with `smem_wdata` = data bits 7:0. A read of port 4 asserts `smem_re` and returns `smem_rdata` in bits 7:0. Both use the 20-bit pointer.
- R8: A write to function 0x4C with data bit 0 clear has these effects:
  - it stores data AND 0xF9 in the reset register;
  - it clears the pending voice flags, DMA control (0x41), timer control (0x45) and sample control (0x49);
  - it sets the voice count (write 0x0E, read 0x8E) to 0xCD;
  - `irq` is low on the next cycle.
  
  A write with bit 0 set only stores the data. Global byte registers read back in bits 7:0, with bits 15:8 zero.
- R9: A read of sample control (0x49) returns bit 6 as 0.
- R10: A set bit of `voice_irq_evt` sets its pending flag, and `irq` is high from the next cycle on. A reset write in the same cycle wins.
- R11: After `rst_n`, the state is as follows:
  - `host_rdata`, `irq` and `smem_addr` are 0;
  - the global registers are 0;
  - the voice count reads 0xCD.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | 3 | Host port code (0..4) |
| host_word | input | 1 | 1 = 16-bit access on the low data port |
| host_wdata | input | 16 | Host write data |
| host_wr | input | 1 | Write strobe, one cycle per write |
| host_rd | input | 1 | Read strobe, one cycle per read |
| host_rdata | output | 16 | Read data, valid one cycle after the strobe |
| voice_irq_evt | input | VOICES | Per-voice interrupt events from the engine |
| irq | output | 1 | Interrupt request, OR of the pending flags |
| smem_addr | output | 20 | Sample-memory address pointer |
| smem_wdata | output | 8 | Sample-memory write byte |
| smem_we | output | 1 | Sample-memory write enable |
| smem_re | output | 1 | Sample-memory read enable |
| smem_rdata | input | 8 | Sample-memory read byte, combinational from `smem_addr` |

## Verification
The hardest case to reach from the ports is a per-voice word built from two byte writes in either order. Every voice and slot must be covered, and the voice select must carry stray upper bits. The bench therefore sweeps all 32 voices by 14 slots. For each entry it rotates among a word write, a low-then-high pair and a high-then-low pair. It mixes in junk upper voice-select bits and the 0x80 read alias. It then reads every entry back through both data ports and compares against an arithmetic pattern. The write gate is reached only by first storing a known word with the enable set, then clearing the enable through a reset write and attempting an overwrite.

// File: rtl/vrp_pkg.sv
package vrp_pkg;
  localparam int DATA_W = 16;
  localparam int BYTE_W = 8;
  localparam int LANES  = DATA_W / BYTE_W;

  typedef enum logic [2:0] {
    PORT_VSEL = 3'd0,
    PORT_FSEL = 3'd1,
    PORT_DLO  = 3'd2,
    PORT_DHI  = 3'd3,
    PORT_SMEM = 3'd4
  } port_e;

  localparam logic [7:0] FN_DMA    = 8'h41;
  localparam logic [7:0] FN_PTR_LO = 8'h43;
  localparam logic [7:0] FN_PTR_HI = 8'h44;
  localparam logic [7:0] FN_TMR    = 8'h45;
  localparam logic [7:0] FN_SAMP   = 8'h49;
  localparam logic [7:0] FN_RST    = 8'h4C;
  localparam logic [7:0] FN_VCNT_W = 8'h0E;
  localparam logic [7:0] FN_VCNT_R = 8'h8E;

  localparam logic [7:0] VCNT_INIT    = 8'hCD;
  localparam logic [7:0] RST_KEEP     = 8'hF9;
  localparam logic [7:0] SAMP_RD_MASK = 8'hBF;

  typedef enum logic [1:0] {
    RS_BYTE = 2'd0,
    RS_LO   = 2'd1,
    RS_HI   = 2'd2
  } rsel_e;

  function automatic logic is_voice_fn(input logic [7:0] f, input int unsigned nfn);
    return (f[6:4] == 3'd0) && (32'(f[3:0]) < nfn);
  endfunction
endpackage

// File: rtl/vrp_voice_ram.sv
module vrp_voice_ram #(
  parameter int DEPTH  = 512,
  parameter int DW     = 16,
  parameter int BW     = 8,
  localparam int NL    = DW / BW,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic [NL-1:0] we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    for (int l = 0; l < NL; l++) begin
      if (we[l]) mem[waddr][l*BW +: BW] <= wdata[l*BW +: BW];
    end
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/vrp_global_regs.sv
module vrp_global_regs
  import vrp_pkg::*;
#(
  parameter int VOICES = 32,
  parameter int PTR_W  = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              gwr,
  input  logic [7:0]        fsel,
  input  logic [LANES-1:0]  lane_we,
  input  logic [BYTE_W-1:0] wlo,
  input  logic [BYTE_W-1:0] whi,
  input  logic [VOICES-1:0] evt,
  output logic [7:0]        dma_ctl,
  output logic [7:0]        tmr_ctl,
  output logic [7:0]        samp_ctl,
  output logic [7:0]        rst_ctl,
  output logic [7:0]        vcnt,
  output logic [PTR_W-1:0]  ptr,
  output logic              irq
);
  localparam int HI_W = PTR_W - DATA_W;

  logic [VOICES-1:0] pend;
  logic              do_reset;

  assign do_reset = gwr && (fsel == FN_RST) && !wlo[0];
  assign irq      = |pend;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend <= '0;
    end else if (do_reset) begin
      pend <= '0;
    end else begin
      pend <= pend | evt;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dma_ctl  <= '0;
      tmr_ctl  <= '0;
      samp_ctl <= '0;
      rst_ctl  <= '0;
      vcnt     <= VCNT_INIT;
      ptr      <= '0;
    end else if (gwr) begin
      unique case (fsel)
        FN_DMA:    dma_ctl  <= wlo;
        FN_TMR:    tmr_ctl  <= wlo;
        FN_SAMP:   samp_ctl <= wlo;
        FN_VCNT_W: vcnt     <= wlo;
        FN_PTR_LO: begin
          if (lane_we[0]) ptr[BYTE_W-1:0]      <= wlo;
          if (lane_we[1]) ptr[DATA_W-1:BYTE_W] <= whi;
        end
        FN_PTR_HI: ptr[PTR_W-1:DATA_W] <= wlo[HI_W-1:0];
        FN_RST: begin
          if (wlo[0]) begin
            rst_ctl <= wlo;
          end else begin
            rst_ctl  <= wlo & RST_KEEP;
            dma_ctl  <= '0;
            tmr_ctl  <= '0;
            samp_ctl <= '0;
            vcnt     <= VCNT_INIT;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/vrp_port.sv
module vrp_port
  import vrp_pkg::*;
#(
  parameter int VOICES  = 32,
  parameter int SLOTS   = 16,
  parameter int NUM_VFN = 14,
  parameter int PTR_W   = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        host_addr,
  input  logic              host_word,
  input  logic [15:0]       host_wdata,
  input  logic              host_wr,
  input  logic              host_rd,
  output logic [15:0]       host_rdata,
  input  logic [VOICES-1:0] voice_irq_evt,
  output logic              irq,
  output logic [PTR_W-1:0]  smem_addr,
  output logic [7:0]        smem_wdata,
  output logic              smem_we,
  output logic              smem_re,
  input  logic [7:0]        smem_rdata
);
  localparam int VOICE_W = $clog2(VOICES);
  localparam int SLOT_W  = $clog2(SLOTS);
  localparam int DEPTH   = VOICES * SLOTS;
  localparam int RAM_AW  = VOICE_W + SLOT_W;

  logic [7:0]  vsel_q, fsel_q;
  logic        is_data, is_lo, is_hi, vfn;
  logic        vwr, vrd, gwr;
  logic [LANES-1:0]  lane_we;
  logic [BYTE_W-1:0] wlo, whi;
  logic [RAM_AW-1:0] ram_a;
  logic [DATA_W-1:0] ram_q;
  logic [7:0]  dma_ctl, tmr_ctl, samp_ctl, rst_ctl, vcnt;
  logic [7:0]  byte_mux, rbyte_q;
  rsel_e       rsel_q;

  // port decode
  assign is_lo   = (host_addr == PORT_DLO);
  assign is_hi   = (host_addr == PORT_DHI);
  assign is_data = is_lo || is_hi;
  assign vfn     = is_voice_fn(fsel_q, NUM_VFN);

  // lane steering: high port always lands in the upper byte
  assign lane_we[0] = is_lo;
  assign lane_we[1] = is_hi || (is_lo && host_word);
  assign wlo        = host_wdata[BYTE_W-1:0];
  assign whi        = is_hi ? host_wdata[BYTE_W-1:0] : host_wdata[DATA_W-1:BYTE_W];

  assign vwr   = host_wr && is_data && vfn && rst_ctl[0];
  assign vrd   = host_rd && is_data && vfn;
  assign gwr   = host_wr && is_data && !vfn;
  assign ram_a = {vsel_q[VOICE_W-1:0], fsel_q[SLOT_W-1:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vsel_q <= '0;
      fsel_q <= '0;
    end else if (host_wr) begin
      if (host_addr == PORT_VSEL) vsel_q <= host_wdata[7:0];
      if (host_addr == PORT_FSEL) fsel_q <= host_wdata[7:0];
    end
  end

  vrp_voice_ram #(
    .DEPTH (DEPTH),
    .DW    (DATA_W),
    .BW    (BYTE_W)
  ) u_ram (
    .clk   (clk),
    .we    (vwr ? lane_we : '0),
    .waddr (ram_a),
    .wdata ({whi, wlo}),
    .re    (vrd),
    .raddr (ram_a),
    .rdata (ram_q)
  );

  vrp_global_regs #(
    .VOICES (VOICES),
    .PTR_W  (PTR_W)
  ) u_glob (
    .clk      (clk),
    .rst_n    (rst_n),
    .gwr      (gwr),
    .fsel     (fsel_q),
    .lane_we  (lane_we),
    .wlo      (wlo),
    .whi      (whi),
    .evt      (voice_irq_evt),
    .dma_ctl  (dma_ctl),
    .tmr_ctl  (tmr_ctl),
    .samp_ctl (samp_ctl),
    .rst_ctl  (rst_ctl),
    .vcnt     (vcnt),
    .ptr      (smem_addr),
    .irq      (irq)
  );

  // sample-memory byte port
  assign smem_we    = host_wr && (host_addr == PORT_SMEM);
  assign smem_re    = host_rd && (host_addr == PORT_SMEM);
  assign smem_wdata = host_wdata[7:0];

  // byte-wide read sources
  always_comb begin
    byte_mux = '0;
    unique case (host_addr)
      PORT_VSEL: byte_mux = vsel_q;
      PORT_FSEL: byte_mux = fsel_q;
      PORT_SMEM: byte_mux = smem_rdata;
      PORT_DLO, PORT_DHI: begin
        unique case (fsel_q)
          FN_DMA:               byte_mux = dma_ctl;
          FN_TMR:               byte_mux = tmr_ctl;
          FN_SAMP:              byte_mux = samp_ctl & SAMP_RD_MASK;
          FN_RST:               byte_mux = rst_ctl;
          FN_VCNT_W, FN_VCNT_R: byte_mux = vcnt;
          default:              byte_mux = '0;
        endcase
      end
      default: byte_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsel_q  <= RS_BYTE;
      rbyte_q <= '0;
    end else if (host_rd) begin
      if (vrd) begin
        rsel_q <= is_hi ? RS_HI : RS_LO;
      end else begin
        rsel_q  <= RS_BYTE;
        rbyte_q <= byte_mux;
      end
    end
  end

  always_comb begin
    unique case (rsel_q)
      RS_LO:   host_rdata = ram_q;
      RS_HI:   host_rdata = {{BYTE_W{1'b0}}, ram_q[DATA_W-1:BYTE_W]};
      default: host_rdata = {{BYTE_W{1'b0}}, rbyte_q};
    endcase
  end
endmodule

// File: rtl/vrp_checker.sv
module vrp_checker
  import vrp_pkg::*;
#(
  parameter int VOICES  = 32,
  parameter int NUM_VFN = 14,
  parameter int PTR_W   = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic [2:0]        host_addr,
  input logic              host_word,
  input logic [15:0]       host_wdata,
  input logic              host_wr,
  input logic              host_rd,
  input logic [15:0]       host_rdata,
  input logic [VOICES-1:0] voice_irq_evt,
  input logic              irq,
  input logic [PTR_W-1:0]  smem_addr,
  input logic [7:0]        fsel_q,
  input logic [7:0]        vcnt
);
  logic dport, rst_wr;
  assign dport  = (host_addr == PORT_DLO) || (host_addr == PORT_DHI);
  assign rst_wr = host_wr && dport && (fsel_q == FN_RST) && !host_wdata[0];

  // R4: high-port per-voice read clears the upper byte
  p_hi_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && host_addr == PORT_DHI && is_voice_fn(fsel_q, NUM_VFN)) |=> (host_rdata[15:8] == 8'h00));

  // R4: read data holds between reads
  p_rdata_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!host_rd && $past(rst_n)) |=> $stable(host_rdata));

  // R6: high pointer bits from the low data nibble, low bits kept
  p_ptr_hi_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && dport && fsel_q == FN_PTR_HI) |=>
      (smem_addr[PTR_W-1:16] == $past(host_wdata[PTR_W-17:0])) &&
      (smem_addr[15:0] == $past(smem_addr[15:0])));

  // R6: word write to the low pointer keeps the upper bits
  p_ptr_lo_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_addr == PORT_DLO && host_word && fsel_q == FN_PTR_LO) |=>
      (smem_addr[15:0] == $past(host_wdata)) &&
      (smem_addr[PTR_W-1:16] == $past(smem_addr[PTR_W-1:16])));

  // R8: reset write drops the interrupt and reloads the voice count
  p_reset_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rst_wr |=> !irq);

  p_reset_vcnt_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rst_wr |=> (vcnt == VCNT_INIT));

  // R9: sample-control bit 6 never reads back
  p_samp_mask_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && dport && fsel_q == FN_SAMP) |=> !host_rdata[6]);

  // R10: an event raises the interrupt unless a reset write coincides
  p_irq_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((|voice_irq_evt) && !rst_wr) |=> irq);
endmodule

bind vrp_port vrp_checker #(
  .VOICES  (VOICES),
  .NUM_VFN (NUM_VFN),
  .PTR_W   (PTR_W)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .host_addr     (host_addr),
  .host_word     (host_word),
  .host_wdata    (host_wdata),
  .host_wr       (host_wr),
  .host_rd       (host_rd),
  .host_rdata    (host_rdata),
  .voice_irq_evt (voice_irq_evt),
  .irq           (irq),
  .smem_addr     (smem_addr),
  .fsel_q        (fsel_q),
  .vcnt          (vcnt)
);

// File: tb/tb_vrp_port.sv
module tb_vrp_port;
  localparam int VOICES = 32;
  localparam int NFN    = 14;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  host_addr = '0;
  logic        host_word = 1'b0;
  logic [15:0] host_wdata = '0;
  logic        host_wr = 1'b0;
  logic        host_rd = 1'b0;
  logic [15:0] host_rdata;
  logic [VOICES-1:0] voice_irq_evt = '0;
  logic        irq;
  logic [19:0] smem_addr;
  logic [7:0]  smem_wdata, smem_rdata;
  logic        smem_we, smem_re;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  assign smem_rdata = smem_addr[7:0] ^ {smem_addr[19:16], smem_addr[11:8]};

  vrp_port dut (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_word(host_word),
    .host_wdata(host_wdata), .host_wr(host_wr), .host_rd(host_rd),
    .host_rdata(host_rdata), .voice_irq_evt(voice_irq_evt), .irq(irq),
    .smem_addr(smem_addr), .smem_wdata(smem_wdata), .smem_we(smem_we),
    .smem_re(smem_re), .smem_rdata(smem_rdata)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr_op(input logic [2:0] p, input logic w, input logic [15:0] d);
    @(negedge clk);
    host_addr = p; host_word = w; host_wdata = d; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic rd_op(input logic [2:0] p, output logic [15:0] v);
    @(negedge clk);
    host_addr = p; host_word = 1'b0; host_rd = 1'b1;
    @(negedge clk);
    host_rd = 1'b0;
    v = host_rdata;
  endtask

  task automatic wr_fn(input logic [7:0] f, input logic [15:0] d);
    wr_op(3'd1, 1'b0, {8'h00, f});
    wr_op(3'd2, 1'b0, d);
  endtask

  task automatic rd_fn(input logic [7:0] f, output logic [15:0] v);
    wr_op(3'd1, 1'b0, {8'h00, f});
    rd_op(3'd2, v);
  endtask

  function automatic logic [15:0] pat(input int v, input int f);
    return 16'((v * NFN + f) * 32'h9E37) ^ 16'h5A3C;
  endfunction

  function automatic logic [7:0] mem_model(input logic [19:0] a);
    return a[7:0] ^ {a[19:16], a[11:8]};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] r;
    logic [15:0] e;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 reset state
    chk("R11 rdata", host_rdata, 0);
    chk("R11 irq", irq, 0);
    chk("R11 smem_addr", smem_addr, 0);
    rd_fn(8'h8E, r); chk("R11 voice count", r, 16'h00CD);
    rd_fn(8'h4C, r); chk("R11 reset reg", r, 0);
    rd_fn(8'h45, r); chk("R11 timer ctl", r, 0);

    // R5 gate: store known word, disable, try overwrite
    wr_fn(8'h4C, 16'h0001);
    wr_op(3'd0, 1'b0, 16'h0002);
    wr_op(3'd1, 1'b0, 16'h0003);
    wr_op(3'd2, 1'b1, 16'hA5A5);
    wr_fn(8'h4C, 16'h0006);
    rd_fn(8'h4C, r); chk("R8 reset keeps mask", r, 16'h0000);
    wr_op(3'd1, 1'b0, 16'h0003);
    wr_op(3'd2, 1'b1, 16'h1234);
    wr_op(3'd3, 1'b0, 16'h0077);
    rd_op(3'd2, r); chk("R5 gated write ignored", r, 16'hA5A5);
    wr_fn(8'h4C, 16'h0007);
    rd_fn(8'h4C, r); chk("R8 enable write stored", r, 16'h0007);

    // R1 R2 R3 sweep
    for (int v = 0; v < VOICES; v++) begin
      for (int f = 0; f < NFN; f++) begin
        e = pat(v, f);
        wr_op(3'd0, 1'b0, 16'(v | ((v & 3) << 5)));
        wr_op(3'd1, 1'b0, 16'(f | (((v + f) & 1) << 7)));
        case ((v + f) % 3)
          0: wr_op(3'd2, 1'b1, e);
          1: begin
            wr_op(3'd2, 1'b0, {~e[15:8], e[7:0]});
            wr_op(3'd3, 1'b0, {~e[7:0], e[15:8]});
          end
          default: begin
            wr_op(3'd3, 1'b1, {8'h5A, e[15:8]});
            wr_op(3'd2, 1'b0, {8'hC3, e[7:0]});
          end
        endcase
      end
    end
    for (int v = 0; v < VOICES; v++) begin
      for (int f = 0; f < NFN; f++) begin
        e = pat(v, f);
        wr_op(3'd0, 1'b0, 16'(v | ((~v & 3) << 5)));
        wr_op(3'd1, 1'b0, 16'(f | ((v & 1) << 7)));
        rd_op(3'd2, r); chk("R1 R2 R3 R4 word readback", r, e);
        rd_op(3'd3, r); chk("R4 high port readback", r, {8'h00, e[15:8]});
      end
    end

    // R2 / R3 single byte lanes on voice 5 slot 2
    e = pat(5, 2);
    wr_op(3'd0, 1'b0, 16'd5);
    wr_op(3'd1, 1'b0, 16'h0002);
    wr_op(3'd2, 1'b0, 16'h99EE);
    rd_op(3'd2, r); chk("R2 low byte only", r, {e[15:8], 8'hEE});
    wr_op(3'd3, 1'b0, 16'h3377);
    rd_op(3'd2, r); chk("R3 high byte only", r, 16'h77EE);

    // R6 pointer
    wr_fn(8'h44, 16'h00AB);
    chk("R6 ptr hi nibble", smem_addr, 20'hB0000);
    wr_op(3'd1, 1'b0, 16'h0043);
    wr_op(3'd2, 1'b1, 16'h1234);
    chk("R6 ptr lo word", smem_addr, 20'hB1234);
    wr_op(3'd2, 1'b0, 16'hFFCD);
    chk("R6 ptr lo byte", smem_addr, 20'hB12CD);
    wr_op(3'd3, 1'b0, 16'h009F);
    chk("R6 ptr hi byte", smem_addr, 20'hB9FCD);
    wr_fn(8'h44, 16'hFFF3);
    chk("R6 ptr upper replaced", smem_addr, 20'h39FCD);

    // R7 sample memory
    @(negedge clk);
    host_addr = 3'd4; host_wdata = 16'hA55C; host_wr = 1'b1;
    #1;
    chk("R7 smem_we", smem_we, 1);
    chk("R7 smem_wdata", smem_wdata, 8'h5C);
    chk("R7 smem_addr", smem_addr, 20'h39FCD);
    @(negedge clk);
    host_wr = 1'b0;
    #1;
    chk("R7 smem_we drop", smem_we, 0);
    rd_op(3'd4, r); chk("R7 smem read", r, {8'h00, mem_model(20'h39FCD)});

    // R9 and global readback
    wr_fn(8'h49, 16'h00FF);
    rd_op(3'd2, r); chk("R9 sample ctl mask", r, 16'h00BF);
    wr_fn(8'h41, 16'hEE3C);
    rd_op(3'd3, r); chk("R8 dma ctl readback", r, 16'h003C);
    wr_fn(8'h45, 16'h000C);
    rd_op(3'd2, r); chk("R8 timer ctl readback", r, 16'h000C);
    wr_fn(8'h0E, 16'h0010);
    rd_fn(8'h8E, r); chk("R8 voice count write", r, 16'h0010);

    // R10 interrupt
    chk("R10 irq idle", irq, 0);
    @(negedge clk);
    voice_irq_evt = 32'h0000_0080;
    @(negedge clk);
    voice_irq_evt = '0;
    chk("R10 irq raised", irq, 1);
    repeat (3) @(negedge clk);
    chk("R10 irq held", irq, 1);

    // R8 reset write
    wr_fn(8'h4C, 16'h00F6);
    chk("R8 irq cleared", irq, 0);
    rd_op(3'd2, r); chk("R8 reset reg masked", r, 16'h00F0);
    rd_fn(8'h41, r); chk("R8 dma cleared", r, 0);
    rd_fn(8'h45, r); chk("R8 timer cleared", r, 0);
    rd_fn(8'h49, r); chk("R8 sample cleared", r, 0);
    rd_fn(8'h8E, r); chk("R8 voice count reload", r, 16'h00CD);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule